// File: doc/BRIEF.md
# USB Low-Speed Packet Receiver

This block takes the two USB data lines, D+ and D-, and returns the bytes of a low-speed packet. The block has its own system clock, with a bit lasting 13⅓ clocks. Both lines are brought into the clock domain through flop synchronisers. While the line is idle the receiver waits for the start of the sync pattern. It then confirms the pattern by finding a J-to-K edge that is followed by a second K bit. From that point it samples each bit near its centre, applies NRZI decoding, drops stuff bits and builds bytes with the least significant bit first.

Each finished byte appears on a byte-wide write strobe. The number of bytes one packet may deliver is limited to a buffer capacity. The packet ends on single-ended zero (SE0), and an end pulse is raised. A packet that exceeds the capacity, a bit sampled with both lines high, and a sync pattern that stops producing edges each end in a one-cycle error pulse. After any of these the receiver goes back to waiting for the idle state. The sampling interval is a whole number of clocks. A leap clock schedule keeps the average interval exact over bytes and over stuff bits.

Top module: `usb_ls_rx`

## Requirements
- R1: While reset is asserted, and when the line stays idle after reset, all five output pulses are low and no byte is written.
- R2: Line states are encoded as {D+, D-}: J = 01, K = 10, SE0 = 00, invalid = 11. A packet is accepted only after a J-to-K edge whose following bit, sampled about 1.5 bit times after the edge, is also K. If that bit is J, the block keeps searching, so a sync pattern with extra K/J pairs in front is still accepted.
- R3: A data bit decodes to 1 when its line state equals the reference state and to 0 otherwise. On a 0 the reference takes the new state. Bytes are assembled with the first bit received as bit 0. Each byte is given as a single-cycle byte_valid_o with byte_data_o.
- R4: After six decoded 1s in a row, the next bit is a stuff bit. It is discarded, the run count restarts at zero, and its line state becomes the reference. The final K-K of the sync pattern counts as the first 1 of a run.
- R5: Samples are spaced 13 or 14 clocks apart. Within a byte, the intervals before bits 3 and 6 are 14 clocks. The interval before bit 0 of a new byte takes one extra clock in two bytes out of three. The interval before a stuff bit takes one extra clock on every third stuff bit. With this spacing, packets of any legal length are decoded without error.
- R6: An SE0 sample ends the packet with a single eop_o pulse. An incomplete byte in progress is dropped.
- R7: A packet delivers at most BUF_BYTES bytes. When byte BUF_BYTES+1 completes, overflow_o pulses, that byte is not written and the packet is abandoned without eop_o.
- R8: While searching for a sync edge, SYNC_TMO clocks without a J-to-K edge raise sync_err_o and stop the search. An idle J line does not start a search.
- R9: A data sample with both lines high (11) abandons the packet with line_err_o and no eop_o.
- R10: After overflow, line error or sync timeout, the block ignores the line until it sees a J. A K held steady after the abort produces no byte and no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, 13⅓ clocks per bit |
| rst_ni | input | 1 | Asynchronous reset, active low |
| dp_i | input | 1 | D+ line, asynchronous |
| dm_i | input | 1 | D- line, asynchronous |
| byte_valid_o | output | 1 | Write strobe for one received byte |
| byte_data_o | output | 8 | Received byte, valid with byte_valid_o |
| eop_o | output | 1 | Pulse: packet ended by SE0 |
| overflow_o | output | 1 | Pulse: packet exceeded BUF_BYTES |
| sync_err_o | output | 1 | Pulse: sync search timed out |
| line_err_o | output | 1 | Pulse: data bit sampled with both lines high |

## Verification
Two events can fall on the same sample. A byte can complete on its bit 7 sample while that same bit brings the run of ones to six. The byte write and the scheduling of a stuff bit then happen together. The bench provokes this with bytes such as 0xFF, 0xFE and 0x7E placed one after another, and with random data biased toward 0xFF. It judges the result by checking that the byte written on that sample is correct, and that the bytes after it decode correctly once the stuff bit has been removed. A second case places the BUF_BYTES+1 byte directly before the SE0. The bench expects an overflow pulse and no end-of-packet pulse.

// File: rtl/usb_ls_rx_pkg.sv
package usb_ls_rx_pkg;
  // {dp, dm}
  typedef enum logic [1:0] {
    LS_SE0 = 2'b00,
    LS_J   = 2'b01,
    LS_K   = 2'b10,
    LS_BAD = 2'b11
  } line_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ARMED,
    ST_CHECK,
    ST_HUNT,
    ST_DATA
  } rx_state_e;

  localparam int BYTE_W = 8;
  localparam int IDX_W  = 3;
endpackage

// File: rtl/usb_ls_line_sync.sv
module usb_ls_line_sync #(
  parameter int          LINES   = 2,
  parameter int          STAGES  = 2,
  parameter logic [LINES-1:0] RST_VAL = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [LINES-1:0] d_i,
  output logic [LINES-1:0] q_o
);
  for (genvar g = 0; g < LINES; g++) begin : g_line
    logic [STAGES-1:0] sr;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) sr <= {STAGES{RST_VAL[g]}};
      else         sr <= {sr[STAGES-2:0], d_i[g]};
    end
    assign q_o[g] = sr[STAGES-1];
  end
endmodule

// File: rtl/usb_ls_bit_timer.sv
module usb_ls_bit_timer
  import usb_ls_rx_pkg::*;
#(
  parameter int BIT_CLKS      = 13,
  parameter int EDGE_TO_CHECK = 20
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             arm_i,
  input  logic             run_i,
  input  logic             first_i,
  input  logic             next_stuff_i,
  input  logic [IDX_W-1:0] next_bit_i,
  output logic             sample_o
);
  localparam int MAXV = (EDGE_TO_CHECK > BIT_CLKS + 2) ? EDGE_TO_CHECK : BIT_CLKS + 2;
  localparam int CW   = $clog2(MAXV + 1);
  localparam logic [CW-1:0] BASE = CW'(BIT_CLKS - 1);

  logic [CW-1:0] tick_q, reload;
  logic [1:0]    byte_ph_q, stf_ph_q;
  logic          leap_pos, leap_byte, leap_stf;

  assign leap_pos  = (next_bit_i == IDX_W'(3)) || (next_bit_i == IDX_W'(6));
  assign leap_byte = (next_bit_i == '0) && (byte_ph_q != 2'd1);
  assign leap_stf  = (stf_ph_q == 2'd2);
  assign sample_o  = run_i && (tick_q == '0);

  always_comb begin
    if (first_i)           reload = BASE;
    else if (next_stuff_i) reload = BASE + CW'(leap_stf);
    else                   reload = BASE + CW'(leap_pos) + CW'(leap_byte);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tick_q    <= '0;
      byte_ph_q <= '0;
      stf_ph_q  <= '0;
    end else if (arm_i) begin
      tick_q    <= CW'(EDGE_TO_CHECK - 1);
      byte_ph_q <= '0;
      stf_ph_q  <= '0;
    end else if (run_i) begin
      if (tick_q == '0) begin
        tick_q <= reload;
        if (!first_i) begin
          if (next_stuff_i)
            stf_ph_q <= (stf_ph_q == 2'd2) ? 2'd0 : stf_ph_q + 2'd1;
          else if (next_bit_i == '0)
            byte_ph_q <= (byte_ph_q == 2'd2) ? 2'd0 : byte_ph_q + 2'd1;
        end
      end else begin
        tick_q <= tick_q - CW'(1);
      end
    end
  end
endmodule

// File: rtl/usb_ls_nrzi.sv
module usb_ls_nrzi
  import usb_ls_rx_pkg::*;
#(
  parameter int STUFF_RUN = 6
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  init_i,
  input  logic  sample_i,
  input  line_e ls_i,
  output logic  bit_o,
  output logic  is_stuff_o,
  output logic  stuff_next_o
);
  localparam int OW = $clog2(STUFF_RUN + 1);

  line_e         ref_q;
  logic [OW-1:0] ones_q;
  logic          stuff_q;

  assign bit_o        = (ls_i == ref_q);
  assign is_stuff_o   = stuff_q;
  assign stuff_next_o = !stuff_q && bit_o && (ones_q == OW'(STUFF_RUN - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ref_q   <= LS_K;
      ones_q  <= '0;
      stuff_q <= 1'b0;
    end else if (init_i) begin
      ref_q   <= LS_K;
      ones_q  <= OW'(1);  // closing K-K of sync counts as a 1
      stuff_q <= 1'b0;
    end else if (sample_i) begin
      if (stuff_q) begin
        ref_q   <= ls_i;
        ones_q  <= '0;
        stuff_q <= 1'b0;
      end else if (bit_o) begin
        ones_q  <= ones_q + OW'(1);
        stuff_q <= stuff_next_o;
      end else begin
        ref_q  <= ls_i;
        ones_q <= '0;
      end
    end
  end
endmodule

// File: rtl/usb_ls_byte_asm.sv
module usb_ls_byte_asm
  import usb_ls_rx_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  logic              shift_i,
  input  logic              bit_i,
  output logic              done_o,
  output logic [BYTE_W-1:0] data_o,
  output logic [IDX_W-1:0]  idx_o
);
  logic [BYTE_W-2:0] sr_q;
  logic [IDX_W-1:0]  idx_q;

  assign done_o = shift_i && (idx_q == IDX_W'(BYTE_W - 1));
  assign data_o = {bit_i, sr_q};
  assign idx_o  = idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q  <= '0;
      idx_q <= '0;
    end else if (clear_i) begin
      idx_q <= '0;
    end else if (shift_i) begin
      sr_q  <= {bit_i, sr_q[BYTE_W-2:1]};
      idx_q <= idx_q + IDX_W'(1);
    end
  end
endmodule

// File: rtl/usb_ls_rx.sv
module usb_ls_rx
  import usb_ls_rx_pkg::*;
#(
  parameter int BUF_BYTES     = 11,
  parameter int BIT_CLKS      = 13,
  parameter int EDGE_TO_CHECK = 20,
  parameter int SYNC_TMO      = 40,
  parameter int SYNC_STAGES   = 2,
  parameter int STUFF_RUN     = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              dp_i,
  input  logic              dm_i,
  output logic              byte_valid_o,
  output logic [BYTE_W-1:0] byte_data_o,
  output logic              eop_o,
  output logic              overflow_o,
  output logic              sync_err_o,
  output logic              line_err_o
);
  localparam int CNT_W  = $clog2(BUF_BYTES + 1);
  localparam int HUNT_W = $clog2(SYNC_TMO);

  logic [1:0]        sync_q;
  line_e             ls, prev_ls_q;
  rx_state_e         state_q;
  logic [CNT_W-1:0]  byte_cnt_q;
  logic [HUNT_W-1:0] hunt_cnt_q;

  logic samp, arm, run, first, line_ok, dsamp, init;
  logic nz_bit, nz_stuff, nz_stuff_next, shift;
  logic asm_done;
  logic [BYTE_W-1:0] asm_byte;
  logic [IDX_W-1:0]  asm_idx, next_bit;
  logic hunt_edge;

  usb_ls_line_sync #(.LINES(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b01)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i({dp_i, dm_i}), .q_o(sync_q)
  );

  assign ls        = line_e'(sync_q);
  assign hunt_edge = (state_q == ST_HUNT) && (ls == LS_K) && (prev_ls_q == LS_J);
  assign arm       = hunt_edge || ((state_q == ST_ARMED) && (ls == LS_K));
  assign run       = (state_q == ST_CHECK) || (state_q == ST_DATA);
  assign first     = (state_q == ST_CHECK);
  assign line_ok   = (ls == LS_J) || (ls == LS_K);
  assign dsamp     = (state_q == ST_DATA) && samp && line_ok;
  assign init      = first && samp && (ls == LS_K);
  assign shift     = dsamp && !nz_stuff;
  assign next_bit  = nz_stuff ? asm_idx : asm_idx + IDX_W'(1);

  usb_ls_bit_timer #(.BIT_CLKS(BIT_CLKS), .EDGE_TO_CHECK(EDGE_TO_CHECK)) u_timer (
    .clk_i(clk_i), .rst_ni(rst_ni), .arm_i(arm), .run_i(run), .first_i(first),
    .next_stuff_i(!nz_stuff && nz_stuff_next), .next_bit_i(next_bit), .sample_o(samp)
  );

  usb_ls_nrzi #(.STUFF_RUN(STUFF_RUN)) u_nrzi (
    .clk_i(clk_i), .rst_ni(rst_ni), .init_i(init), .sample_i(dsamp), .ls_i(ls),
    .bit_o(nz_bit), .is_stuff_o(nz_stuff), .stuff_next_o(nz_stuff_next)
  );

  usb_ls_byte_asm u_asm (
    .clk_i(clk_i), .rst_ni(rst_ni), .clear_i(init), .shift_i(shift), .bit_i(nz_bit),
    .done_o(asm_done), .data_o(asm_byte), .idx_o(asm_idx)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q      <= ST_IDLE;
      prev_ls_q    <= LS_J;
      byte_cnt_q   <= '0;
      hunt_cnt_q   <= '0;
      byte_valid_o <= 1'b0;
      byte_data_o  <= '0;
      eop_o        <= 1'b0;
      overflow_o   <= 1'b0;
      sync_err_o   <= 1'b0;
      line_err_o   <= 1'b0;
    end else begin
      prev_ls_q    <= ls;
      byte_valid_o <= 1'b0;
      eop_o        <= 1'b0;
      overflow_o   <= 1'b0;
      sync_err_o   <= 1'b0;
      line_err_o   <= 1'b0;
      unique case (state_q)
        ST_IDLE:  if (ls == LS_J) state_q <= ST_ARMED;
        ST_ARMED: if (ls == LS_K) state_q <= ST_CHECK;
        ST_CHECK: if (samp) begin
          if (ls == LS_K) begin
            state_q    <= ST_DATA;
            byte_cnt_q <= '0;
          end else begin
            state_q    <= ST_HUNT;
            hunt_cnt_q <= '0;
          end
        end
        ST_HUNT: begin
          if (hunt_edge) begin
            state_q <= ST_CHECK;
          end else if (hunt_cnt_q == HUNT_W'(SYNC_TMO - 1)) begin
            state_q    <= ST_IDLE;
            sync_err_o <= 1'b1;
          end else begin
            hunt_cnt_q <= hunt_cnt_q + HUNT_W'(1);
          end
        end
        ST_DATA: if (samp) begin
          if (ls == LS_SE0) begin
            state_q <= ST_IDLE;
            eop_o   <= 1'b1;
          end else if (ls == LS_BAD) begin
            state_q    <= ST_IDLE;
            line_err_o <= 1'b1;
          end else if (asm_done) begin
            if (byte_cnt_q == CNT_W'(BUF_BYTES)) begin
              state_q    <= ST_IDLE;
              overflow_o <= 1'b1;
            end else begin
              byte_valid_o <= 1'b1;
              byte_data_o  <= asm_byte;
              byte_cnt_q   <= byte_cnt_q + CNT_W'(1);
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/usb_ls_rx_chk.sv
module usb_ls_rx_chk #(
  parameter int BUF_BYTES = 11
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       byte_valid_o,
  input logic [7:0] byte_data_o,
  input logic       eop_o,
  input logic       overflow_o,
  input logic       sync_err_o,
  input logic       line_err_o
);
  localparam int CW = $clog2(BUF_BYTES + 2);
  logic [CW-1:0] seen_q;
  logic          end_ev;

  assign end_ev = eop_o || overflow_o || sync_err_o || line_err_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           seen_q <= '0;
    else if (end_ev)       seen_q <= '0;
    else if (byte_valid_o) seen_q <= seen_q + CW'(1);
  end

  a_r3_byte_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_valid_o |=> !byte_valid_o);

  a_r3_data_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !byte_valid_o |=> $stable(byte_data_o) || byte_valid_o);

  a_r6_eop_alone: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eop_o |-> !byte_valid_o);

  a_r9_one_end: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({eop_o, overflow_o, sync_err_o, line_err_o}));

  a_r7_cap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_valid_o |-> seen_q < CW'(BUF_BYTES));

  a_r7_ovf_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
    overflow_o |-> !byte_valid_o && seen_q == CW'(BUF_BYTES));

  a_r10_quiet_after_abort: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (overflow_o || line_err_o || sync_err_o) |=> !byte_valid_o && !eop_o);
endmodule

bind usb_ls_rx usb_ls_rx_chk #(.BUF_BYTES(BUF_BYTES)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .byte_valid_o(byte_valid_o), .byte_data_o(byte_data_o),
  .eop_o(eop_o), .overflow_o(overflow_o), .sync_err_o(sync_err_o), .line_err_o(line_err_o)
);

// File: tb/sim_usb_ls_rx.sv
module sim_usb_ls_rx;
  localparam int BUF = 11;
  localparam logic [1:0] J = 2'b01, K = 2'b10, SE0 = 2'b00, BAD = 2'b11;

  logic clk = 1'b0, rst_n = 1'b0, dp = 1'b0, dm = 1'b1;
  logic byte_valid, eop, overflow, sync_err, line_err;
  logic [7:0] byte_data;

  always #2 clk = ~clk;

  usb_ls_rx #(.BUF_BYTES(BUF)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .dp_i(dp), .dm_i(dm),
    .byte_valid_o(byte_valid), .byte_data_o(byte_data), .eop_o(eop),
    .overflow_o(overflow), .sync_err_o(sync_err), .line_err_o(line_err)
  );

  int checks = 0, errors = 0;
  bit done = 0;
  logic [7:0] got[$];
  int n_eop = 0, n_ovf = 0, n_serr = 0, n_lerr = 0;

  always @(negedge clk) if (rst_n) begin
    if (byte_valid) got.push_back(byte_data);
    if (eop) n_eop++;
    if (overflow) n_ovf++;
    if (sync_err) n_serr++;
    if (line_err) n_lerr++;
  end

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
    end
  endtask

  // stimulus model
  logic [1:0] sym[$];
  logic [7:0] tx[$];
  logic [1:0] cur;
  int ones;
  int m_got = 0, m_eop = 0, m_ovf = 0, m_serr = 0, m_lerr = 0;

  task automatic start_pkt(input int pairs);
    sym.delete(); tx.delete();
    for (int i = 0; i < pairs; i++) begin sym.push_back(K); sym.push_back(J); end
    for (int i = 0; i < 3; i++) begin sym.push_back(K); sym.push_back(J); end
    sym.push_back(K); sym.push_back(K);
    cur = K; ones = 1;
  endtask

  task automatic enc_bit(input logic b);
    if (!b) begin cur = ~cur; ones = 0; end
    else ones++;
    sym.push_back(cur);
    if (ones == 6) begin cur = ~cur; sym.push_back(cur); ones = 0; end
  endtask

  task automatic enc_byte(input logic [7:0] b);
    for (int i = 0; i < 8; i++) enc_bit(b[i]);
    tx.push_back(b);
  endtask

  task automatic play();
    @(negedge clk);
    for (int k = 0; k < sym.size(); k++) begin
      {dp, dm} = sym[k];
      repeat (((k + 1) * 40) / 3 - (k * 40) / 3) @(negedge clk);
    end
  endtask

  task automatic idle(input int n);
    {dp, dm} = J;
    repeat (n) @(negedge clk);
  endtask

  task automatic mark();
    m_got = got.size(); m_eop = n_eop; m_ovf = n_ovf; m_serr = n_serr; m_lerr = n_lerr;
  endtask

  // expected: bytes up to BUF, overflow beyond, else tail decides eop or line error
  task automatic expect_pkt(input string req, input bit bad_tail, input bit serr);
    int nexp, ngot, e_eop, e_ovf, e_lerr;
    nexp  = (tx.size() > BUF) ? BUF : tx.size();
    e_ovf = (tx.size() > BUF) ? 1 : 0;
    e_eop = (!e_ovf && !bad_tail && !serr) ? 1 : 0;
    e_lerr = (!e_ovf && bad_tail) ? 1 : 0;
    ngot = got.size() - m_got;
    check(ngot == nexp, req, "byte count", ngot, nexp);
    for (int i = 0; i < nexp && i < ngot; i++)
      check(got[m_got + i] == tx[i], req, $sformatf("byte %0d", i), got[m_got + i], tx[i]);
    check(n_eop - m_eop == e_eop, req, "eop pulses", n_eop - m_eop, e_eop);
    check(n_ovf - m_ovf == e_ovf, "R7", "overflow pulses", n_ovf - m_ovf, e_ovf);
    check(n_serr - m_serr == int'(serr), "R8", "sync_err pulses", n_serr - m_serr, int'(serr));
    check(n_lerr - m_lerr == e_lerr, "R9", "line_err pulses", n_lerr - m_lerr, e_lerr);
    mark();
  endtask

  task automatic eop_tail();
    sym.push_back(SE0); sym.push_back(SE0); sym.push_back(J);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL R5 watchdog: got %0d expected %0d", 0, 1);
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (5) @(negedge clk);
    // R1 reset state
    check({byte_valid, eop, overflow, sync_err, line_err} == 5'b0, "R1", "outputs in reset",
          {byte_valid, eop, overflow, sync_err, line_err}, 0);
    rst_n = 1'b1;
    idle(300);
    mark();
    tx.delete();
    check(got.size() == 0 && n_serr == 0 && n_eop == 0, "R1", "idle line events",
          got.size() + n_serr + n_eop, 0);

    // R3 basic decoding
    start_pkt(0);
    enc_byte(8'hA5); enc_byte(8'h3C); enc_byte(8'h00); enc_byte(8'h96);
    eop_tail(); play(); idle(60);
    expect_pkt("R3", 0, 0);

    // R4 stuffing, stuff on byte boundary (R4 with byte write on same sample)
    start_pkt(0);
    enc_byte(8'hFF); enc_byte(8'hFF); enc_byte(8'h7E); enc_byte(8'hFE);
    enc_byte(8'h01); enc_byte(8'h80); enc_byte(8'h3F); enc_byte(8'hFC);
    eop_tail(); play(); idle(60);
    expect_pkt("R4", 0, 0);

    // R2 extended sync pattern
    start_pkt(3);
    enc_byte(8'h5A); enc_byte(8'hC3);
    eop_tail(); play(); idle(60);
    expect_pkt("R2", 0, 0);

    // R5 full-length packet
    start_pkt(0);
    for (int i = 0; i < BUF; i++) enc_byte(8'(i * 37 + 5));
    eop_tail(); play(); idle(60);
    expect_pkt("R5", 0, 0);

    // R7 overflow on byte BUF+1, placed just before SE0
    start_pkt(0);
    for (int i = 0; i < BUF + 1; i++) enc_byte(8'(i * 91 + 17));
    eop_tail(); play(); idle(60);
    expect_pkt("R7", 0, 0);

    // R6 SE0 in the middle of a byte
    start_pkt(0);
    enc_byte(8'h4B);
    enc_bit(1'b1); enc_bit(1'b0); enc_bit(1'b1);
    eop_tail(); play(); idle(60);
    expect_pkt("R6", 0, 0);

    // R8 single K then idle: sync search times out
    tx.delete();
    @(negedge clk);
    {dp, dm} = K;
    repeat (13) @(negedge clk);
    idle(200);
    expect_pkt("R8", 0, 1);

    // R9 invalid state, then R10 steady K after abort
    start_pkt(0);
    enc_byte(8'h12); enc_byte(8'hEF);
    sym.push_back(BAD);
    play();
    {dp, dm} = K;
    repeat (150) @(negedge clk);
    expect_pkt("R9", 1, 0);
    check(got.size() - m_got == 0 && n_serr == m_serr, "R10", "events while K held",
          got.size() - m_got + n_serr - m_serr, 0);
    idle(60);
    mark();
    start_pkt(0);
    enc_byte(8'h69); enc_byte(8'hF0);
    eop_tail(); play(); idle(60);
    expect_pkt("R10", 0, 0);

    // random packets (R3, R4, R5)
    for (int p = 0; p < 30; p++) begin
      int len;
      len = $urandom_range(1, BUF);
      start_pkt($urandom_range(0, 2));
      for (int i = 0; i < len; i++) begin
        logic [7:0] b;
        b = 8'($urandom());
        if ($urandom_range(0, 3) == 0) b = 8'hFF;
        enc_byte(b);
      end
      eop_tail(); play(); idle(40 + $urandom_range(0, 30));
      expect_pkt("R5", 0, 0);
    end

    done = 1;
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule